// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs a parallel-output sampling converter from the host side. It drives the active-low convert strobe, chip-select, read strobe and, when asked, a gated converter clock. It watches the converter's busy line through a two-flop synchroniser and captures each finished result from the parallel data bus. The result is presented to the host as a data word with a one-cycle valid strobe.

Two power modes are supported. In fast mode the convert strobe is only a short low pulse, and a settling (acquisition) gap is kept between a read and the next conversion. In sleep mode the strobe is left low after the conversion, so the converter powers down. The next conversion first raises the strobe to wake it, waits a programmable wake-up time, and then lowers the strobe. A burst option stops the converter clock outside conversions. After reset the block runs one throw-away conversion, because the converter's first result cannot be trusted. Samples are requested by a start pulse or by a built-in rate counter. A request that comes while a conversion is under way is refused with a strobe. If busy does not finish in time, a watchdog raises an error.

Top module: `adc_conv_seq`

## Requirements
- R1: During reset, adc_cnv, adc_cs_n and adc_rd_n are high and res_valid is low. After reset one conversion and one read run without any request, and that read produces no res_valid.
- R2: In fast mode (cfg_sleep=0) a request drives adc_cnv low for exactly CNV_LOW (default 2) clock cycles and then high again, before busy falls. The captured data then appears on res_data.
- R3: In sleep mode (cfg_sleep=1), adc_cnv rises for a conversion, stays high exactly cfg_wake+1 cycles and then falls. It stays low after the read ends.
- R4: In fast mode, with req_start held high, adc_cnv falls exactly cfg_acq+2 cycles after adc_rd_n returns high.
- R5: adc_cs_n and adc_rd_n go low only after synchronised busy has fallen. They stay low RD_CYC cycles, and adc_cnv does not move while they are low.
- R6: With cfg_res12=0 only the low DW-2 bits of the bus are kept, and bits 11 and 10 of res_data read 0. With cfg_res12=1 all 12 bits are kept.
- R7: res_valid is high for exactly one cycle per non-dummy conversion. res_data holds its value until the next valid result.
- R8: A request (req_start or a rate tick) that arrives while the block is not idle pulses req_rej and starts no conversion.
- R9: With cfg_auto=1, conversions start every cfg_period cycles: the spacing between falling edges of adc_cnv is cfg_period.
- R10: With cfg_burst=1, adc_clk stays low outside conversions. Its first rising edge comes less than 4 host cycles (two converter-clock periods) after adc_cnv falls.
- R11: In burst mode the read does not begin until adc_clk has given at least 14 rising edges (cfg_res12=1) or 12 (cfg_res12=0) since adc_cnv fell.
- R12: With cfg_burst=0, adc_clk toggles on every host cycle.
- R13: If busy has not risen and fallen within cfg_wdog cycles after the strobe phase, wdog_err pulses, adc_cnv returns high, no read occurs and the block goes idle.
- R14: adc_cnv never falls while adc_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sleep | input | 1 | 1 = sleep mode, 0 = fast mode |
| cfg_res12 | input | 1 | 1 = 12-bit result, 0 = 10-bit |
| cfg_burst | input | 1 | 1 = gate converter clock to conversions |
| cfg_auto | input | 1 | 1 = rate counter issues requests |
| cfg_period | input | TW | Rate counter period in host cycles |
| cfg_acq | input | TW | Acquisition gap after a read (fast mode) |
| cfg_wake | input | TW | Wake-up wait in sleep mode |
| cfg_wdog | input | TW | Busy watchdog limit |
| req_start | input | 1 | Sample request |
| adc_cnv | output | 1 | Convert strobe, falling edge starts |
| adc_busy | input | 1 | Converter busy (asynchronous) |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_data | input | DW | Parallel result bus |
| adc_clk | output | 1 | Converter clock (host clock / 2) |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | DW | Captured result |
| req_rej | output | 1 | Request refused strobe |
| wdog_err | output | 1 | Busy watchdog expiry strobe |

## Verification
Every cycle, the checker confirms the following. The strobe never falls while busy is high. In fast mode the strobe is already high when busy falls. Reads happen only while busy is low and with a steady strobe. The result and error strobes behave as single pulses, and the burst clock starts within two converter periods. The exact waits cannot be seen from any one cycle, so only the directed scenarios show them: the wake-up count, the acquisition gap, the rate period, and the discarded dummy result. The same holds for the width masking, the refusal of requests made mid-conversion, the converter-clock edge count and the watchdog recovery.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAKE,
        ST_CNV_LO,
        ST_WAIT,
        ST_READ,
        ST_ACQ
    } seq_state_e;

endpackage

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
module adc_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] sr_q;
    logic [STAGES-1:0] sr_d;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sync_out = sr_q[STAGES-1];
endmodule

// File: rtl/adc_seq_rate.sv
`timescale 1ns/1ps
module adc_seq_rate #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [TW-1:0] period,
    output logic          tick
);
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_d;
    logic          last;

    always_comb begin
        last  = (period == '0) || (cnt_q >= period - TW'(1));
        tick  = en && last;
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (last) cnt_d = '0;
        else           cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_seq_cclk.sv
`timescale 1ns/1ps
module adc_seq_cclk #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clr,
    output logic          cclk,
    output logic [CW-1:0] rises
);
    localparam logic [CW-1:0] SAT = '1;

    typedef struct packed {
        logic          ck;
        logic [CW-1:0] cnt;
    } cclk_regs_t;

    cclk_regs_t q, d;

    always_comb begin
        d    = q;
        d.ck = run ? !q.ck : 1'b0;
        if (clr)
            d.cnt = '0;
        else if (run && !q.ck && q.cnt != SAT)
            d.cnt = q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cclk  = q.ck;
    assign rises = q.cnt;
endmodule

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int DW      = 12,
    parameter int TW      = 16,
    parameter int CNV_LOW = 2,
    parameter int RD_CYC  = 2,
    parameter int MIN_LO  = 12,
    parameter int MIN_HI  = 14,
    parameter int SYNC_ST = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_sleep,
    input  logic          cfg_res12,
    input  logic          cfg_burst,
    input  logic          cfg_auto,
    input  logic [TW-1:0] cfg_period,
    input  logic [TW-1:0] cfg_acq,
    input  logic [TW-1:0] cfg_wake,
    input  logic [TW-1:0] cfg_wdog,
    input  logic          req_start,
    output logic          adc_cnv,
    input  logic          adc_busy,
    output logic          adc_cs_n,
    output logic          adc_rd_n,
    input  logic [DW-1:0] adc_data,
    output logic          adc_clk,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic          req_rej,
    output logic          wdog_err
);
    localparam int            CW      = $clog2(MIN_HI + 1) + 1;
    localparam int            LOW_RES = DW - 2;
    localparam logic [CW-1:0] NEED_HI = CW'(MIN_HI);
    localparam logic [CW-1:0] NEED_LO = CW'(MIN_LO);
    localparam logic [TW-1:0] LOW_LD  = TW'(CNV_LOW - 1);
    localparam logic [TW-1:0] RD_LD   = TW'(RD_CYC - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] tmr;
        logic          cnv;
        logic          cs_n;
        logic          rd_n;
        logic          seen_busy;
        logic          dummy;
        logic          valid;
        logic [DW-1:0] data;
        logic          rej;
        logic          err;
    } seq_regs_t;

    seq_regs_t q, d;

    logic          busy_s;
    logic          tick;
    logic          clk_run;
    logic          clr_rise;
    logic [CW-1:0] rises;
    logic [CW-1:0] need;
    logic [TW-1:0] tmr_dec;
    logic [DW-1:0] masked;
    logic          req;

    adc_seq_sync #(.STAGES(SYNC_ST)) i_busy_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (adc_busy),
        .sync_out (busy_s)
    );

    adc_seq_rate #(.TW(TW)) i_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cfg_auto),
        .period (cfg_period),
        .tick   (tick)
    );

    adc_seq_cclk #(.CW(CW)) i_cclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (clk_run),
        .clr   (clr_rise),
        .cclk  (adc_clk),
        .rises (rises)
    );

    // Converter clock runs freely, or only while a conversion is in flight.
    assign clk_run = !cfg_burst || (q.st == ST_CNV_LO) || (q.st == ST_WAIT);
    assign need    = cfg_res12 ? NEED_HI : NEED_LO;
    assign req     = req_start || tick;

    always_comb begin
        for (int i = 0; i < DW; i++)
            masked[i] = adc_data[i] & (cfg_res12 || (i < LOW_RES));
    end

    always_comb begin
        d        = q;
        d.valid  = 1'b0;
        d.rej    = 1'b0;
        d.err    = 1'b0;
        clr_rise = 1'b0;
        tmr_dec  = (q.tmr == '0) ? '0 : q.tmr - TW'(1);

        if (req && !(q.st == ST_IDLE && !q.dummy))
            d.rej = 1'b1;

        case (q.st)
            ST_IDLE: begin
                d.cnv = cfg_sleep ? q.cnv : 1'b1;
                if (q.dummy || req) begin
                    d.seen_busy = 1'b0;
                    if (cfg_sleep) begin
                        d.st  = ST_WAKE;
                        d.cnv = 1'b1;
                        d.tmr = cfg_wake;
                    end else begin
                        d.st     = ST_CNV_LO;
                        d.cnv    = 1'b0;
                        d.tmr    = LOW_LD;
                        clr_rise = 1'b1;
                    end
                end
            end
            ST_WAKE: begin
                d.tmr = tmr_dec;
                if (q.tmr == '0) begin
                    d.st     = ST_CNV_LO;
                    d.cnv    = 1'b0;
                    d.tmr    = LOW_LD;
                    clr_rise = 1'b1;
                end
            end
            ST_CNV_LO: begin
                d.tmr = tmr_dec;
                if (q.tmr == '0) begin
                    d.cnv = !cfg_sleep;
                    d.st  = ST_WAIT;
                    d.tmr = cfg_wdog;
                end
            end
            ST_WAIT: begin
                d.tmr = tmr_dec;
                if (busy_s) d.seen_busy = 1'b1;
                if (q.seen_busy && !busy_s && rises >= need) begin
                    d.st   = ST_READ;
                    d.cs_n = 1'b0;
                    d.rd_n = 1'b0;
                    d.tmr  = RD_LD;
                end else if (q.tmr == '0) begin
                    d.err   = 1'b1;
                    d.st    = ST_IDLE;
                    d.cnv   = 1'b1;
                    d.dummy = 1'b0;
                end
            end
            ST_READ: begin
                d.tmr = tmr_dec;
                if (q.tmr == '0) begin
                    if (!q.dummy) begin
                        d.data  = masked;
                        d.valid = 1'b1;
                    end
                    d.dummy = 1'b0;
                    d.cs_n  = 1'b1;
                    d.rd_n  = 1'b1;
                    d.st    = cfg_sleep ? ST_IDLE : ST_ACQ;
                    d.tmr   = cfg_acq;
                end
            end
            ST_ACQ: begin
                d.tmr = tmr_dec;
                if (q.tmr == '0) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.cnv   <= 1'b1;
            q.cs_n  <= 1'b1;
            q.rd_n  <= 1'b1;
            q.dummy <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign adc_cnv   = q.cnv;
    assign adc_cs_n  = q.cs_n;
    assign adc_rd_n  = q.rd_n;
    assign res_valid = q.valid;
    assign res_data  = q.data;
    assign req_rej   = q.rej;
    assign wdog_err  = q.err;
endmodule

// File: rtl/adc_conv_seq_chk.sv
`timescale 1ns/1ps
module adc_conv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_sleep,
    input logic cfg_burst,
    input logic adc_cnv,
    input logic adc_busy,
    input logic adc_rd_n,
    input logic adc_clk,
    input logic res_valid,
    input logic wdog_err
);
    logic       cnv_p, ck_p, pend;
    logic [2:0] lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_p <= 1'b1;
            ck_p  <= 1'b0;
            pend  <= 1'b0;
            lat   <= '0;
        end else begin
            cnv_p <= adc_cnv;
            ck_p  <= adc_clk;
            if (cfg_burst && cnv_p && !adc_cnv) begin
                pend <= 1'b1;
                lat  <= '0;
            end else if (pend && !ck_p && adc_clk) begin
                pend <= 1'b0;
            end else if (pend && lat != 3'd7) begin
                lat <= lat + 3'd1;
            end
        end
    end

    p_no_restart_r14: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cnv) |-> !adc_busy);

    p_fast_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sleep && $fell(adc_busy)) |-> adc_cnv);

    p_read_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rd_n |-> !adc_busy);

    p_read_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_rd_n && $past(!adc_rd_n)) |-> $stable(adc_cnv));

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_err_clean_r13: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_err |-> (adc_cnv && !res_valid && adc_rd_n));

    p_burst_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (lat < 3'd4));
endmodule

bind adc_conv_seq adc_conv_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_sleep (cfg_sleep),
    .cfg_burst (cfg_burst),
    .adc_cnv   (adc_cnv),
    .adc_busy  (adc_busy),
    .adc_rd_n  (adc_rd_n),
    .adc_clk   (adc_clk),
    .res_valid (res_valid),
    .wdog_err  (wdog_err)
);

// File: tb/test_adc_conv_seq.sv
`timescale 1ns/1ps
module test_adc_conv_seq;
    localparam int DW = 12;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_sleep = 1'b0, cfg_res12 = 1'b1, cfg_burst = 1'b0, cfg_auto = 1'b0;
    logic [TW-1:0] cfg_period = 16'd100, cfg_acq = 16'd8, cfg_wake = 16'd20, cfg_wdog = 16'd200;
    logic          req_start = 1'b0;
    logic          adc_cnv, adc_cs_n, adc_rd_n, adc_clk, res_valid, req_rej, wdog_err;
    logic          adc_busy = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic [DW-1:0] res_data;

    always #2.5 clk = ~clk;

    adc_conv_seq i_adc_conv_seq (
        .clk(clk), .rst_n(rst_n), .cfg_sleep(cfg_sleep), .cfg_res12(cfg_res12),
        .cfg_burst(cfg_burst), .cfg_auto(cfg_auto), .cfg_period(cfg_period),
        .cfg_acq(cfg_acq), .cfg_wake(cfg_wake), .cfg_wdog(cfg_wdog),
        .req_start(req_start), .adc_cnv(adc_cnv), .adc_busy(adc_busy),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_data(adc_data),
        .adc_clk(adc_clk), .res_valid(res_valid), .res_data(res_data),
        .req_rej(req_rej), .wdog_err(wdog_err)
    );

    // Converter model: arms on a strobe fall, converts on its clock.
    logic          stuck = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          m_cnv_p, m_ck_p, armed;
    logic [4:0]    m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnv_p <= 1'b1; m_ck_p <= 1'b0; armed <= 1'b0; adc_busy <= 1'b0; m_cnt <= '0;
        end else begin
            m_cnv_p <= adc_cnv;
            m_ck_p  <= adc_clk;
            if (m_cnv_p && !adc_cnv) armed <= 1'b1;
            if (!m_ck_p && adc_clk) begin
                if (adc_busy) begin
                    if (!stuck) begin
                        if (m_cnt >= (cfg_res12 ? 5'd13 : 5'd11)) begin
                            adc_busy <= 1'b0;
                            adc_data <= sample;
                        end else m_cnt <= m_cnt + 5'd1;
                    end
                end else if (armed) begin
                    adc_busy <= 1'b1; armed <= 1'b0; m_cnt <= '0;
                end
            end
        end
    end

    // Monitor, sampled between edges.
    int cyc = 0, fall_cyc = 0, rise_cyc = 0, rdrise_cyc = 0, first_lat = 0;
    int n_fall = 0, n_read = 0, n_valid = 0, n_rej = 0, n_err = 0;
    int bad_fall = 0, dbl_valid = 0, rise_cnt = 0, rises_at_read = 0;
    logic p_cnv = 1'b1, p_ck = 1'b0, p_rd = 1'b1, p_val = 1'b0, lat_pend = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (p_cnv && !adc_cnv) begin
            fall_cyc = cyc; n_fall++; lat_pend = 1'b1; rise_cnt = 0;
            if (adc_busy) bad_fall++;
        end
        if (!p_cnv && adc_cnv) rise_cyc = cyc;
        if (!p_ck && adc_clk) begin
            rise_cnt++;
            if (lat_pend) begin first_lat = cyc - fall_cyc; lat_pend = 1'b0; end
        end
        if (p_rd && !adc_rd_n) begin n_read++; rises_at_read = rise_cnt; end
        if (!p_rd && adc_rd_n) rdrise_cyc = cyc;
        if (res_valid) n_valid++;
        if (res_valid && p_val) dbl_valid++;
        if (req_rej) n_rej++;
        if (wdog_err) n_err++;
        p_cnv = adc_cnv; p_ck = adc_clk; p_rd = adc_rd_n; p_val = res_valid;
    end

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); req_start = 1'b1;
        @(negedge clk); req_start = 1'b0;
    endtask

    task automatic wait_valid(input int base, input int limit);
        for (int i = 0; i < limit && n_valid <= base; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(adc_cnv && adc_cs_n && adc_rd_n && !res_valid, "R1 reset outputs",
            {adc_cnv, adc_cs_n, adc_rd_n, res_valid}, 4'b1110);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 200 && n_read == 0; i++) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(n_read == 1, "R1 dummy read", n_read, 1);
        chk(n_valid == 0, "R1 dummy discarded", n_valid, 0);
    endtask

    task automatic t_fast();
        int b = n_valid;
        sample = 12'hABC;
        pulse_start();
        wait_valid(b, 200);
        chk(rise_cyc - fall_cyc == 2, "R2 strobe width", rise_cyc - fall_cyc, 2);
        chk(res_data == 12'hABC, "R2 data", res_data, 12'hABC);
        @(negedge clk);
        chk(!res_valid, "R7 single pulse", res_valid, 0);
        repeat (5) @(negedge clk);
        chk(res_data == 12'hABC, "R7 data held", res_data, 12'hABC);
        chk(rises_at_read >= 14, "R5 read after conversion", rises_at_read, 14);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_res10();
        int b = n_valid;
        cfg_res12 = 1'b0; sample = 12'hFFF;
        pulse_start();
        wait_valid(b, 200);
        chk(res_data == 12'h3FF, "R6 ten-bit mask", res_data, 12'h3FF);
        repeat (20) @(negedge clk);
        cfg_res12 = 1'b1;
    endtask

    task automatic t_reject();
        int bv = n_valid, bf = n_fall, br = n_rej;
        sample = 12'h123;
        pulse_start();
        repeat (4) @(negedge clk);
        pulse_start();
        wait_valid(bv, 200);
        repeat (25) @(negedge clk);
        chk(n_rej == br + 1, "R8 reject strobe", n_rej - br, 1);
        chk(n_fall == bf + 1, "R8 no extra conversion", n_fall - bf, 1);
        chk(n_valid == bv + 1, "R8 one result", n_valid - bv, 1);
    endtask

    task automatic t_acq();
        int bf = n_fall;
        @(negedge clk); req_start = 1'b1;
        for (int i = 0; i < 300 && n_fall < bf + 2; i++) @(negedge clk);
        req_start = 1'b0;
        chk(fall_cyc - rdrise_cyc == 10, "R4 acquisition gap", fall_cyc - rdrise_cyc, 10);
        repeat (80) @(negedge clk);
    endtask

    task automatic t_sleep();
        int b = n_valid;
        cfg_sleep = 1'b1; sample = 12'h5A5;
        pulse_start();
        wait_valid(b, 300);
        chk(res_data == 12'h5A5, "R3 sleep data", res_data, 12'h5A5);
        repeat (5) @(negedge clk);
        chk(!adc_cnv, "R3 strobe left low", adc_cnv, 0);
        b = n_valid;
        pulse_start();
        wait_valid(b, 300);
        chk(fall_cyc - rise_cyc == 21, "R3 wake time", fall_cyc - rise_cyc, 21);
        repeat (10) @(negedge clk);
        cfg_sleep = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_burst();
        int b, hi = 0;
        cfg_burst = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (adc_clk) hi++; end
        chk(hi == 0, "R10 clock stopped when idle", hi, 0);
        b = n_valid;
        pulse_start();
        wait_valid(b, 200);
        chk(first_lat <= 3, "R10 clock start latency", first_lat, 3);
        chk(rises_at_read >= 14, "R11 twelve-bit edges", rises_at_read, 14);
        repeat (20) @(negedge clk);
        cfg_res12 = 1'b0; b = n_valid;
        pulse_start();
        wait_valid(b, 200);
        chk(rises_at_read >= 12, "R11 ten-bit edges", rises_at_read, 12);
        repeat (20) @(negedge clk);
        cfg_res12 = 1'b1; cfg_burst = 1'b0;
    endtask

    task automatic t_cont();
        int tg = 0;
        logic pv;
        @(negedge clk); pv = adc_clk;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (adc_clk != pv) tg++; pv = adc_clk; end
        chk(tg == 10, "R12 free-running clock", tg, 10);
    endtask

    task automatic t_auto();
        int bf = n_fall, br = n_rej, f1 = 0;
        cfg_auto = 1'b1;
        for (int i = 0; i < 500 && n_fall < bf + 1; i++) @(negedge clk);
        f1 = fall_cyc;
        for (int i = 0; i < 500 && n_fall < bf + 2; i++) @(negedge clk);
        cfg_auto = 1'b0;
        chk(fall_cyc - f1 == 100, "R9 rate period", fall_cyc - f1, 100);
        chk(n_rej == br, "R9 no refused ticks", n_rej - br, 0);
        repeat (80) @(negedge clk);
    endtask

    task automatic t_wdog();
        int bv = n_valid, be = n_err, br = n_read;
        stuck = 1'b1;
        pulse_start();
        repeat (260) @(negedge clk);
        chk(n_err == be + 1, "R13 watchdog error", n_err - be, 1);
        chk(n_valid == bv && n_read == br, "R13 no read", n_read - br, 0);
        chk(adc_cnv, "R13 strobe released", adc_cnv, 1);
        stuck = 1'b0;
        repeat (60) @(negedge clk);
        chk(bad_fall == 0, "R14 no strobe fall during busy", bad_fall, 0);
        chk(dbl_valid == 0, "R7 no stretched valid", dbl_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual cycles %0d expected fewer than %0d", cyc, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fast();
        t_res10();
        t_reject();
        t_acq();
        t_sleep();
        t_burst();
        t_cont();
        t_auto();
        t_wdog();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule